// File: doc/BRIEF.md
# Vernier Oscillator Measurement Sequencer

This block runs the control loop of one conversion in a time-to-digital converter that is built from two gated ring oscillators, one slow and one fast. The block waits for a reference edge and starts the slow oscillator and its lap counter. It then waits for the edge from the controlled oscillator. On that edge it snapshots the stage levels of the slow ring and starts the fast ring and its edge counter. It keeps both rings running until the arbiter matrix reports that any arbiter has fired. At that point it stops both rings and issues a one-cycle decode request. It then issues a one-cycle clear that resets the counters and the arbiter flip-flops, whose data pins are tied high. After the clear it opens both inputs again for the next pair of edges.

All three event inputs arrive from outside the control clock domain. Each passes through a synchronizer of SYNC_STAGES flops. The two edge inputs are then rising-edge detected, and the arbiter flag is used as a level. An input changes the phase on the posedge SYNC_STAGES+1 after the input changes. The block watches the wait for the second edge and the wait for an arbiter hit with separate cycle limits. If either limit runs out, the conversion is dropped and the block goes straight to the clear.

Top module: `vernier_meas_sequencer`

## Requirements
- R1: While rst_n is low, clr_all is 1 and ref_gate, dco_gate, slow_run, fast_run, snap_slow and decode_go are 0. On the first clock edge after release, the block becomes armed with ref_gate=1 and dco_gate=1, and every other output is 0.
- R2: A rising edge on ref_in while the block is armed makes slow_run=1, ref_gate=0 and dco_gate=1. This takes effect on exactly the (SYNC_STAGES+1)-th rising clock edge after the input rises, and not earlier.
- R3: A rising edge on dco_in while only the slow ring runs makes fast_run=1 with slow_run kept at 1, and makes dco_gate=0. It takes effect with the same latency as R2. snap_slow is 1 for exactly the first cycle in which fast_run is 1.
- R4: hit_any at 1 while both rings run, after the same latency, gives decode_go=1 for one cycle. In that cycle slow_run and fast_run are 0.
- R5: The cycle after decode_go, clr_all is 1 for one cycle and all other outputs are 0. In the cycle after that, the block is armed again as in R1.
- R6: A rising edge on dco_in while the block is armed is ignored. The outputs stay at the armed values.
- R7: While only the slow ring runs, further rising edges on ref_in are ignored, and so is hit_any. The outputs stay at the values of R2.
- R8: If no usable dco_in edge arrives, slow_run stays 1 for exactly DCO_WAIT_MAX cycles. The block then spends one cycle in clr_all=1 without ever raising decode_go.
- R9: If hit_any does not arrive, the state with both rings running lasts exactly HIT_WAIT_MAX cycles. The block then spends one cycle in clr_all=1 without raising decode_go.
- R10: An event that is recognised on the same edge on which a wait limit would expire is accepted, and the timeout does not take it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference edge input, asynchronous |
| dco_in | input | 1 | Controlled-oscillator edge input, asynchronous |
| hit_any | input | 1 | Any-arbiter-fired flag, asynchronous level |
| ref_gate | output | 1 | Reference input enabled |
| dco_gate | output | 1 | Oscillator input enabled |
| slow_run | output | 1 | Slow ring and lap counter enable |
| fast_run | output | 1 | Fast ring and edge counter enable |
| snap_slow | output | 1 | One-cycle strobe to capture slow ring stage levels |
| decode_go | output | 1 | One-cycle request to search and decode arbiter position |
| clr_all | output | 1 | Clear of counters and arbiter flip-flops |

## Verification
The bench checks the exact cycle on which each input takes effect. A design that has one synchronizer flop too many or too few changes phase one cycle off and is caught. Edges and hit flags are applied in the wrong phase: an early controlled-oscillator edge, extra reference edges, and a premature arbiter flag. A design that acted on any of these would start a ring or decode with no valid interval. Both wait limits are run out and then hit on their final edge. This catches a counter that expires one cycle early or late, and a counter that lets the timeout win over a real event. The snapshot strobe and the clear after decode are checked for width and position, because a missing clear leaves the arbiter flip-flops stuck high.

// File: rtl/vtdc_seq_pkg.sv
package vtdc_seq_pkg;

   typedef enum logic [2:0] {
      PH_CLEAR  = 3'd0,
      PH_ARM    = 3'd1,
      PH_SLOW   = 3'd2,
      PH_BOTH   = 3'd3,
      PH_DECODE = 3'd4
   } phase_t;

endpackage

// File: rtl/vtdc_edge_sync.sv
module vtdc_edge_sync #(
   parameter int STAGES      = 2,
   parameter bit DETECT_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic evt_o
);

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end

      if (DETECT_RISE) begin : g_rise
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last_q <= 1'b0;
            else        last_q <= chain_q[STAGES-1];
         end
         assign evt_o = chain_q[STAGES-1] & ~last_q;

         // R2
         rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o |=> !evt_o);
      end else begin : g_level
         assign evt_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/vtdc_watchdog.sv
module vtdc_watchdog #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic [CW-1:0] limit_i,
   output logic          expired_o
);

   logic [CW-1:0] cnt_q;

   assign expired_o = (cnt_q == limit_i - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart_i)  cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + CW'(1);
   end

   // R8
   cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit_i);

endmodule

// File: rtl/vtdc_seq_fsm.sv
module vtdc_seq_fsm
   import vtdc_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ref_rise_i,
   input  logic   dco_rise_i,
   input  logic   hit_lvl_i,
   input  logic   expired_i,
   output phase_t phase_o,
   output logic   restart_o,
   output logic   snap_o
);

   phase_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_CLEAR:  state_d = PH_ARM;
         PH_ARM:    if (ref_rise_i) state_d = PH_SLOW;
         PH_SLOW:   if (dco_rise_i)     state_d = PH_BOTH;
                    else if (expired_i) state_d = PH_CLEAR;
         PH_BOTH:   if (hit_lvl_i)      state_d = PH_DECODE;
                    else if (expired_i) state_d = PH_CLEAR;
         PH_DECODE: state_d = PH_CLEAR;
         default:   state_d = PH_CLEAR;
      endcase
   end

   assign restart_o = (state_d != state_q);
   assign phase_o   = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_CLEAR;
         snap_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         snap_o  <= (state_q == PH_SLOW) && dco_rise_i;
      end
   end

   // R8
   dco_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_SLOW && expired_i && !dco_rise_i) |=> state_q == PH_CLEAR);

   // R6
   idle_dco_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_ARM && !ref_rise_i) |=> state_q == PH_ARM);

   // R9
   hit_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_BOTH && expired_i && !hit_lvl_i) |=> state_q == PH_CLEAR);

endmodule

// File: rtl/vernier_meas_sequencer.sv
module vernier_meas_sequencer
   import vtdc_seq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DCO_WAIT_MAX = 40,
   parameter int HIT_WAIT_MAX = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic dco_in,
   input  logic hit_any,
   output logic ref_gate,
   output logic dco_gate,
   output logic slow_run,
   output logic fast_run,
   output logic snap_slow,
   output logic decode_go,
   output logic clr_all
);

   localparam int WAIT_TOP = (DCO_WAIT_MAX > HIT_WAIT_MAX) ? DCO_WAIT_MAX : HIT_WAIT_MAX;
   localparam int CW       = $clog2(WAIT_TOP + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DCO_WAIT_MAX < SYNC_STAGES + 2 || HIT_WAIT_MAX < SYNC_STAGES + 2) begin : g_bad_wait
         $error("wait limits must exceed the synchronizer latency");
      end
   endgenerate

   logic   ref_rise, dco_rise, hit_lvl, expired, restart, snap;
   phase_t phase;
   logic [CW-1:0] limit;

   vtdc_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ref_in), .evt_o(ref_rise));

   vtdc_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_dco_sync (
      .clk(clk), .rst_n(rst_n), .async_i(dco_in), .evt_o(dco_rise));

   vtdc_edge_sync #(.STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) u_hit_sync (
      .clk(clk), .rst_n(rst_n), .async_i(hit_any), .evt_o(hit_lvl));

   assign limit = (phase == PH_BOTH) ? CW'(HIT_WAIT_MAX) : CW'(DCO_WAIT_MAX);

   vtdc_watchdog #(.CW(CW)) u_wdog (
      .clk(clk), .rst_n(rst_n), .restart_i(restart), .limit_i(limit),
      .expired_o(expired));

   vtdc_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ref_rise_i(ref_rise), .dco_rise_i(dco_rise),
      .hit_lvl_i(hit_lvl), .expired_i(expired), .phase_o(phase),
      .restart_o(restart), .snap_o(snap));

   always_comb begin
      clr_all   = (phase == PH_CLEAR);
      ref_gate  = (phase == PH_ARM);
      dco_gate  = (phase == PH_ARM) || (phase == PH_SLOW);
      slow_run  = (phase == PH_SLOW) || (phase == PH_BOTH);
      fast_run  = (phase == PH_BOTH);
      decode_go = (phase == PH_DECODE);
   end
   assign snap_slow = snap;

   // R3
   fast_needs_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_run |-> slow_run);

   // R2
   ref_gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_run |-> !ref_gate);

   // R5
   clear_after_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decode_go |=> clr_all);

   // R5
   rearm_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (ref_gate && dco_gate));

   // R3
   snap_on_fast_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_run) |-> snap_slow);

   // R3
   snap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_slow |=> !snap_slow);

   // R4
   decode_stops_rings_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decode_go |-> (!slow_run && !fast_run && $past(fast_run)));

endmodule

// File: tb/sim_vernier_meas_sequencer.sv
module sim_vernier_meas_sequencer;

   localparam int SYNC = 2;
   localparam int DMAX = 40;
   localparam int HMAX = 16;
   localparam int LAT  = SYNC + 1;

   typedef enum int {X_CLR, X_ARM, X_SLOW, X_BOTH, X_SNAP, X_DEC} exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_in = 1'b0, dco_in = 1'b0, hit_any = 1'b0;
   logic ref_gate, dco_gate, slow_run, fast_run, snap_slow, decode_go, clr_all;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   vernier_meas_sequencer #(.SYNC_STAGES(SYNC), .DCO_WAIT_MAX(DMAX), .HIT_WAIT_MAX(HMAX)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dco_in(dco_in), .hit_any(hit_any),
      .ref_gate(ref_gate), .dco_gate(dco_gate), .slow_run(slow_run), .fast_run(fast_run),
      .snap_slow(snap_slow), .decode_go(decode_go), .clr_all(clr_all));

   // {clr_all, ref_gate, dco_gate, slow_run, fast_run, snap_slow, decode_go}
   function automatic logic [6:0] expect_of(exp_t e);
      case (e)
         X_CLR:   return 7'b1000000;
         X_ARM:   return 7'b0110000;
         X_SLOW:  return 7'b0011000;
         X_BOTH:  return 7'b0001100;
         X_SNAP:  return 7'b0001110;
         default: return 7'b0000001;
      endcase
   endfunction

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, exp_t e);
      logic [6:0] got;
      got = {clr_all, ref_gate, dco_gate, slow_run, fast_run, snap_slow, decode_go};
      n_chk++;
      if (got !== expect_of(e)) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, expect_of(e));
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // One conversion from the armed state. gap/hgap in cycles; flags select corner cases.
   task automatic convert(int gap, int hgap, bit no_dco, bit no_hit, bit stray, bit noise);
      if (stray) begin
         dco_in = 1'b1; tick(LAT + 1); dco_in = 1'b0; tick(LAT);
         chk("R6 early dco edge ignored", X_ARM);
      end
      ref_in = 1'b1;
      tick(LAT - 1); chk("R2 latency not early", X_ARM);
      tick(1);       chk("R2 slow ring started", X_SLOW);
      ref_in = 1'b0;
      if (no_dco) begin
         tick(DMAX - 1); chk("R8 still waiting for dco", X_SLOW);
         tick(1);        chk("R8 dco timeout clears", X_CLR);
         tick(1);        chk("R8 rearmed", X_ARM);
         return;
      end
      if (noise) begin
         ref_in = 1'b1; hit_any = 1'b1; tick(LAT + 1);
         ref_in = 1'b0; hit_any = 1'b0; tick(LAT);
         chk("R7 ref and hit ignored", X_SLOW);
      end
      tick(gap);
      dco_in = 1'b1;
      tick(LAT); chk("R3 fast ring started with snap", X_SNAP);
      dco_in = 1'b0;
      tick(1);   chk("R3 snap lasts one cycle", X_BOTH);
      if (no_hit) begin
         tick(HMAX - 2); chk("R9 still waiting for hit", X_BOTH);
         tick(1);        chk("R9 hit timeout clears", X_CLR);
         tick(1);        chk("R9 rearmed", X_ARM);
         return;
      end
      tick(hgap);
      hit_any = 1'b1;
      tick(LAT); chk("R4 decode request", X_DEC);
      hit_any = 1'b0;
      tick(1);   chk("R5 clear after decode", X_CLR);
      tick(1);   chk("R5 rearmed", X_ARM);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      int seed = 1234;
      void'($urandom(seed));
      tick(2);
      chk("R1 reset state", X_CLR);
      rst_n = 1'b1;
      tick(1);
      chk("R1 armed after reset", X_ARM);

      convert(5, 3, 0, 0, 0, 0);
      convert(2, 1, 0, 0, 1, 0);
      convert(0, 0, 0, 0, 0, 1);
      convert(0, 0, 1, 0, 0, 0);
      convert(4, 0, 0, 1, 0, 0);
      // R10 boundary: events recognised on the expiry edge
      convert(DMAX - LAT, HMAX - LAT - 1, 0, 0, 0, 0);
      convert(DMAX - LAT - 1, HMAX - LAT - 2, 0, 0, 0, 0);

      for (int i = 0; i < 40; i++) begin
         int g = $urandom_range(DMAX - LAT, 0);
         int h = $urandom_range(HMAX - LAT - 1, 0);
         int r = $urandom_range(9, 0);
         convert(g, h, r == 0, r == 1, r == 2, r == 3);
         tick($urandom_range(3, 0));
         chk("R5 idle between conversions", X_ARM);
      end
      summary();
   end

endmodule